// File: doc/BRIEF.md
# Priority-Ordered Multifunction Register

This block is an N-bit register that can hold its value, load a parallel word, shift left by one position, clear every bit to zero or set every bit to one. All of these happen on the rising clock edge. Four independent one-bit requests choose the operation: clear, set, load and shift-left. When more than one request is high, a fixed priority decides which one acts. Clear wins over set, set wins over load, and load wins over shift-left. With no request high, the register keeps its contents.

Inside, the requests are encoded into a three-bit select. That select drives a per-bit eight-way multiplexer in front of each flip-flop. The three select codes that the encoder never produces fall back to hold.

During a left shift, each bit takes the value of the bit below it, and the serial input enters at the least significant position. The most significant bit is dropped. A synchronous active-low reset clears the register so that the bench and the checks start from a known state.

Top module: `prio_shift_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `q` becomes all zeros at that edge.
- R2: With `clr`, `set`, `ld` and `shl` all low at an edge, `q` keeps its previous value.
- R3: With `ld` high and `clr` and `set` low, `q` takes the value of `din` at the edge, whatever `shl` is.
- R4: With only `shl` high, `q` becomes `{q[W-2:0], ser_in}` at the edge. The old `q[W-1]` is lost.
- R5: With `clr` high, `q` becomes all zeros at the edge, whatever the other three requests are.
- R6: With `set` high and `clr` low, `q` becomes all ones at the edge, whatever `ld` and `shl` are.
- R7: Clear and set act only at a rising edge. Raising either one between edges leaves `q` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | W | Parallel load word |
| ser_in | input | 1 | Bit shifted into the LSB on a left shift |
| clr | input | 1 | Clear request, highest priority |
| set | input | 1 | Set-to-ones request |
| ld | input | 1 | Parallel load request |
| shl | input | 1 | Shift-left request, lowest priority |
| q | output | W | Register contents |

## Verification
Every operation shows up on `q` exactly one rising edge after the requests that chose it are presented. There is no other pipeline stage.

The bench drives the requests and data at the falling edge and updates its behavioural model at the same moment. It then compares `q` with the model at the next falling edge, half a period after the register has updated.

For R7, the bench also samples `q` between the moment clear or set is raised and the next rising edge, to confirm that nothing has moved yet. All sixteen request combinations are applied, each starting from a freshly loaded random value.

// File: rtl/prio_shift_reg.sv
module prio_shift_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         ser_in,
  input  logic         clr,
  input  logic         set,
  input  logic         ld,
  input  logic         shl,
  output logic [W-1:0] q
);
  localparam logic [2:0] OP_LOAD = 3'b001;
  localparam logic [2:0] OP_SHL  = 3'b010;
  localparam logic [2:0] OP_CLR  = 3'b011;
  localparam logic [2:0] OP_SET  = 3'b100;

  logic [2:0]   sel;
  logic [W-1:0] nxt;

  assign sel[2] = !clr & set;
  assign sel[1] = clr | (!clr & !set & !ld & shl);
  assign sel[0] = clr | (!clr & !set & ld);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lo, nb;
    if (i == 0) begin : g_lsb
      assign lo = ser_in;
    end else begin : g_up
      assign lo = q[i-1];
    end
    always_comb begin
      case (sel)
        OP_LOAD: nb = din[i];
        OP_SHL:  nb = lo;
        OP_CLR:  nb = 1'b0;
        OP_SET:  nb = 1'b1;
        default: nb = q[i];
      endcase
    end
    assign nxt[i] = nb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set && !ld && !shl) |=> $stable(q)); // R2
  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set && ld) |=> (q == $past(din))); // R3
  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set && !ld && shl) |=> (q == {$past(q[W-2:0]), $past(ser_in)})); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0)); // R5
  AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && set) |=> (q == '1)); // R6
endmodule

// File: tb/prio_shift_reg_test.sv
module prio_shift_reg_test;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] din = '0;
  logic         ser_in = 1'b0;
  logic         clr = 1'b0, set = 1'b0, ld = 1'b0, shl = 1'b0;
  logic [W-1:0] q;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;

  prio_shift_reg #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .din(din), .ser_in(ser_in),
    .clr(clr), .set(set), .ld(ld), .shl(shl), .q(q)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s q=%b expected=%b", tag, q, exp);
    end
  endtask

  function automatic string tag_of(input logic c, s, l, h);
    if (c) return "R5";
    if (s) return "R6";
    if (l) return "R3";
    if (h) return "R4";
    return "R2";
  endfunction

  // Drive at the falling edge, update the model, compare at the next falling edge.
  task automatic step(input logic c, s, l, h, input logic [W-1:0] d, input logic si);
    string t;
    clr = c; set = s; ld = l; shl = h; din = d; ser_in = si;
    if (c)      model = '0;
    else if (s) model = ONES;
    else if (l) model = d;
    else if (h) model = {model[W-2:0], si};
    t = tag_of(c, s, l, h);
    @(negedge clk);
    check(t, model);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog q=%b expected=done", q);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", '0);
    din = 4'b1010; ld = 1'b1;
    @(negedge clk);
    check("R1", '0);
    ld = 1'b0;
    rst_n = 1'b1;
    model = '0;

    step(0, 0, 1, 0, 4'b1001, 0);
    step(0, 0, 0, 1, 4'b0000, 0);
    step(0, 0, 0, 1, 4'b0000, 1);
    step(0, 0, 0, 1, 4'b1111, 1);
    step(0, 0, 0, 0, 4'b0101, 1);
    step(0, 0, 0, 0, 4'b0000, 0);

    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] start, d;
      start = W'($urandom);
      d = W'($urandom);
      step(0, 0, 1, 0, start, 0);
      step(k[3], k[2], k[1], k[0], d, 1'($urandom));
    end

    // R7: requests raised mid-cycle must not move q before the next edge.
    step(0, 0, 1, 0, 4'b0110, 0);
    clr = 1'b1;
    #5;
    check("R7", 4'b0110);
    @(negedge clk);
    model = '0;
    check("R7", '0);
    step(0, 0, 0, 0, 4'b0000, 0);
    clr = 1'b0; set = 1'b1;
    #5;
    check("R7", '0);
    @(negedge clk);
    model = ONES;
    check("R7", ONES);

    for (int k = 0; k < 200; k++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(r[3] & r[2], r[2] & r[1], r[1], r[0], W'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule